// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler with Power-up Initialisation

This block keeps an asynchronous DRAM refreshed by issuing CAS-before-RAS refresh cycles. The device's internal row counter picks the row, so no row address has to be supplied. An interval timer marks each point at which one more row is owed. A debt counter keeps the owed refreshes that have not yet been served. A request/grant handshake with the access controller decides when the scheduler may take the strobes. While it holds them it drives its own RAS, CAS and WE sequence. Every timing value is a parameter counted in clock cycles.

After reset the block first waits out the power-up pause. It then issues a fixed number of initialisation refresh cycles, back to back, as grants arrive. Only after that does it raise `init_done` and release the hold on host accesses. If the debt grows so large that the refresh period must be taken as exceeded, the block drops `init_done` and runs the whole pause and initialisation again. A smaller debt threshold raises an urgent request, which also holds off host traffic.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is applied and on the cycle after it, `dram_ras_n`, every `dram_cas_n` bit and `dram_we_n` are 1, and `init_done`, `ref_req`, `ref_urgent` and `ref_own` are 0, with `host_hold` at 1.
- R2: After reset, and after a refresh loss, no strobe moves and `ref_req` stays 0 for INIT_PAUSE_CYC cycles. When `ref_gnt` is already high, the first CAS fall is observed INIT_PAUSE_CYC+1 clock edges after the pause begins.
- R3: After the pause, exactly INIT_REFS refresh cycles are issued. `init_done` rises on the clock edge that ends the precharge of the last of them. `host_hold` stays 1 until then and goes to 0 with it when the debt is below URGENT_DEBT.
- R4: Every refresh cycle follows the same sequence. CAS is low for exactly T_CSR cycles before RAS falls and stays low for exactly T_CHR cycles after. RAS is low for exactly T_RAS cycles. Both strobes are high for at least T_RP cycles before CAS falls again. All bits of `dram_cas_n` move together.
- R5: `dram_we_n` is 1 in every cycle.
- R6: Once `init_done` is high, one refresh is owed every REFI_CYC cycles. The first one is owed REFI_CYC edges after `init_done` rises.
- R7: `ref_req` is high exactly when a refresh is owed and no refresh cycle is in progress. A cycle starts on the edge after `ref_req` and `ref_gnt` are both high. `ref_own` is high for exactly the cycles in which the block drives the strobes. `ref_gnt` without `ref_req` has no effect.
- R8: Each interval tick adds one to the debt and each completed refresh removes one. When a tick and a completion fall on the same edge, the debt is unchanged. Once the debt is served, the number of refreshes issued since `init_done` rose equals the number of ticks.
- R9: `ref_urgent` and `host_hold` are high while the debt is at least URGENT_DEBT. `ref_urgent` rises on the edge of the URGENT_DEBT-th unserved tick.
- R10: When the debt reaches LOSS_DEBT, `init_done` falls on the following edge, the debt is cleared and `ref_req` is 0. The full pause and INIT_REFS initialisation refreshes then repeat.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Access controller lets the scheduler take the strobes |
| ref_req | output | 1 | A refresh is owed and the sequencer is idle |
| ref_urgent | output | 1 | Debt is at or above the urgent threshold |
| ref_own | output | 1 | Scheduler is driving the strobes |
| host_hold | output | 1 | Host accesses must not start |
| init_done | output | 1 | Power-up initialisation is complete |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | NUM_CAS | Column strobes (upper and lower), active low, driven together |
| dram_we_n | output | 1 | Write enable, held high |

## Verification
The interval tick and the completion of a refresh can land on the same clock edge, and the debt counter must then stay where it is. The bench withholds the grant until the debt sits at the urgent threshold. It then raises the grant at a computed cycle, so that the end of the first refresh coincides with the next tick. If the debt is handled correctly, `ref_urgent` stays high across that edge and falls only when the next refresh completes. A lost tick would make `ref_urgent` fall one refresh early, and a lost completion would make it fall one refresh late.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    // Refresh strobe sequencer states, in the order they are walked.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CSR,   // CAS low, RAS high: setup before RAS falls
        SEQ_CHR,   // CAS low, RAS low: CAS hold after RAS falls
        SEQ_HOLD,  // CAS high, RAS low: rest of the RAS pulse
        SEQ_PRE    // both high: RAS precharge
    } seq_state_t;

    // Scheduler phases.
    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    // Width of a counter that walks 0 .. n-1.
    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic seq_state_t seq_next(seq_state_t s);
        case (s)
            SEQ_CSR:  return SEQ_CHR;
            SEQ_CHR:  return SEQ_HOLD;
            SEQ_HOLD: return SEQ_PRE;
            default:  return SEQ_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer
    import cbr_pkg::*;
#(
    parameter int unsigned REFI_CYC = 780
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned W = cnt_width(REFI_CYC);
    localparam logic [W-1:0] LAST = W'(REFI_CYC - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/cbr_debt_counter.sv
module cbr_debt_counter
    import cbr_pkg::*;
#(
    parameter int unsigned URGENT_DEBT = 8,
    parameter int unsigned LOSS_DEBT   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic inc,
    input  logic dec,
    output logic owed,
    output logic urgent,
    output logic lost
);
    localparam int unsigned W = $clog2(LOSS_DEBT + 1);
    localparam logic [W-1:0] FULL = W'(LOSS_DEBT);
    localparam logic [W-1:0] URG  = W'(URGENT_DEBT);

    logic [W-1:0] debt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            debt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (debt_q != FULL) debt_q <= debt_q + 1'b1;
                2'b01:   if (debt_q != '0)   debt_q <= debt_q - 1'b1;
                default: debt_q <= debt_q;   // none, or tick and completion together
            endcase
        end
    end

    assign owed   = en && (debt_q != '0);
    assign urgent = en && (debt_q >= URG);
    assign lost   = en && (debt_q == FULL);

endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
    import cbr_pkg::*;
#(
    parameter int unsigned T_CSR   = 1,
    parameter int unsigned T_CHR   = 1,
    parameter int unsigned T_RAS   = 5,
    parameter int unsigned T_RP    = 3,
    parameter int unsigned NUM_CAS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               want,
    input  logic               gnt,
    output logic               req,
    output logic               own,
    output logic               done,
    output logic               ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n
);
    // T_RAS must exceed T_CHR; every segment lasts at least one cycle.
    localparam int unsigned T_HOLD = T_RAS - T_CHR;
    localparam int unsigned MAXD   = max2(max2(T_CSR, T_CHR), max2(T_HOLD, T_RP));
    localparam int unsigned CW     = cnt_width(MAXD);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          seg_end;
    strobe_t       st;

    function automatic logic [CW-1:0] seg_last(seq_state_t s);
        case (s)
            SEQ_CSR:  return CW'(T_CSR - 1);
            SEQ_CHR:  return CW'(T_CHR - 1);
            SEQ_HOLD: return CW'(T_HOLD - 1);
            SEQ_PRE:  return CW'(T_RP - 1);
            default:  return '0;
        endcase
    endfunction

    assign seg_end = (cnt_q == seg_last(state_q));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (state_q == SEQ_IDLE) begin
            cnt_d = '0;
            if (want && gnt) state_d = SEQ_CSR;
        end else if (seg_end) begin
            cnt_d   = '0;
            state_d = seq_next(state_q);
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        st.ras_n = !((state_q == SEQ_CHR) || (state_q == SEQ_HOLD));
        st.cas_n = !((state_q == SEQ_CSR) || (state_q == SEQ_CHR));
        st.we_n  = 1'b1;
    end

    assign req   = want && (state_q == SEQ_IDLE);
    assign own   = (state_q != SEQ_IDLE);
    assign done  = (state_q == SEQ_PRE) && seg_end;
    assign ras_n = st.ras_n;
    assign we_n  = st.we_n;

    for (genvar g = 0; g < NUM_CAS; g++) begin : g_cas
        assign cas_n[g] = st.cas_n;
    end

endmodule

// File: rtl/cbr_init_ctrl.sv
module cbr_init_ctrl
    import cbr_pkg::*;
#(
    parameter int unsigned INIT_PAUSE_CYC = 20000,
    parameter int unsigned INIT_REFS      = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic seq_done,
    input  logic lost,
    output logic run,
    output logic init_want
);
    localparam int unsigned PW = cnt_width(INIT_PAUSE_CYC);
    localparam int unsigned RW = cnt_width(INIT_REFS);
    localparam logic [PW-1:0] P_LAST = PW'(INIT_PAUSE_CYC - 1);
    localparam logic [RW-1:0] R_LAST = RW'(INIT_REFS - 1);

    phase_t        phase_q;
    logic [PW-1:0] pause_q;
    logic [RW-1:0] refs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_PAUSE;
            pause_q <= '0;
            refs_q  <= '0;
        end else begin
            case (phase_q)
                PH_PAUSE: begin
                    if (pause_q == P_LAST) begin
                        phase_q <= PH_INIT;
                        refs_q  <= '0;
                    end else begin
                        pause_q <= pause_q + 1'b1;
                    end
                end
                PH_INIT: begin
                    if (seq_done) begin
                        if (refs_q == R_LAST) phase_q <= PH_RUN;
                        else                  refs_q  <= refs_q + 1'b1;
                    end
                end
                default: begin
                    if (lost) begin
                        phase_q <= PH_PAUSE;
                        pause_q <= '0;
                    end
                end
            endcase
        end
    end

    assign run       = (phase_q == PH_RUN);
    assign init_want = (phase_q == PH_INIT);

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_pkg::*;
#(
    parameter int unsigned INIT_PAUSE_CYC = 20000,
    parameter int unsigned INIT_REFS      = 8,
    parameter int unsigned REFI_CYC       = 780,
    parameter int unsigned URGENT_DEBT    = 8,
    parameter int unsigned LOSS_DEBT      = 16,
    parameter int unsigned T_CSR          = 1,
    parameter int unsigned T_CHR          = 1,
    parameter int unsigned T_RAS          = 5,
    parameter int unsigned T_RP           = 3,
    parameter int unsigned NUM_CAS        = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_gnt,
    output logic               ref_req,
    output logic               ref_urgent,
    output logic               ref_own,
    output logic               host_hold,
    output logic               init_done,
    output logic               dram_ras_n,
    output logic [NUM_CAS-1:0] dram_cas_n,
    output logic               dram_we_n
);
    logic run, init_want, tick, owed, urgent, lost, seq_done;

    cbr_init_ctrl #(
        .INIT_PAUSE_CYC(INIT_PAUSE_CYC),
        .INIT_REFS     (INIT_REFS)
    ) init_i (
        .clk      (clk),
        .rst      (rst),
        .seq_done (seq_done),
        .lost     (lost),
        .run      (run),
        .init_want(init_want)
    );

    cbr_interval_timer #(
        .REFI_CYC(REFI_CYC)
    ) timer_i (
        .clk (clk),
        .rst (rst),
        .en  (run),
        .tick(tick)
    );

    cbr_debt_counter #(
        .URGENT_DEBT(URGENT_DEBT),
        .LOSS_DEBT  (LOSS_DEBT)
    ) debt_i (
        .clk   (clk),
        .rst   (rst),
        .en    (run),
        .inc   (tick),
        .dec   (seq_done),
        .owed  (owed),
        .urgent(urgent),
        .lost  (lost)
    );

    cbr_strobe_seq #(
        .T_CSR  (T_CSR),
        .T_CHR  (T_CHR),
        .T_RAS  (T_RAS),
        .T_RP   (T_RP),
        .NUM_CAS(NUM_CAS)
    ) seq_i (
        .clk  (clk),
        .rst  (rst),
        .want (init_want || owed),
        .gnt  (ref_gnt),
        .req  (ref_req),
        .own  (ref_own),
        .done (seq_done),
        .ras_n(dram_ras_n),
        .cas_n(dram_cas_n),
        .we_n (dram_we_n)
    );

    assign ref_urgent = urgent;
    assign init_done  = run;
    assign host_hold  = !run || urgent;

endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
    parameter int unsigned NUM_CAS = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               ref_gnt,
    input logic               ref_req,
    input logic               ref_urgent,
    input logic               ref_own,
    input logic               host_hold,
    input logic               init_done,
    input logic               dram_ras_n,
    input logic [NUM_CAS-1:0] dram_cas_n
);
    // R4: CAS was already low in the cycle before RAS falls
    p_cas_before_ras_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> ($past(dram_cas_n[0]) == 1'b0));

    // R4: CAS is still low in the cycle RAS falls
    p_cas_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(dram_ras_n) |-> (dram_cas_n[0] == 1'b0));

    // R7: strobes rest high whenever the scheduler does not own them
    p_idle_strobes_r7: assert property (@(posedge clk) disable iff (rst)
        !ref_own |-> (dram_ras_n && (&dram_cas_n)));

    // R7: no request while a cycle runs
    p_no_req_while_own_r7: assert property (@(posedge clk) disable iff (rst)
        ref_own |-> !ref_req);

    // R7: a cycle only starts after request and grant met
    p_start_needs_gnt_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_own) |-> $past(ref_req && ref_gnt));

    // R3: hosts held off until initialisation completes
    p_hold_until_init_r3: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> host_hold);

    // R9: an urgent request always holds off hosts
    p_urgent_holds_r9: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> host_hold);

    // R10: on loss the debt is dropped, so no request remains
    p_loss_clears_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(init_done) |-> !ref_req);

endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(.NUM_CAS(NUM_CAS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ref_gnt   (ref_gnt),
    .ref_req   (ref_req),
    .ref_urgent(ref_urgent),
    .ref_own   (ref_own),
    .host_hold (host_hold),
    .init_done (init_done),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n)
);

// File: tb/cbr_refresh_sched_tb.sv
`timescale 1ns/1ps
module cbr_refresh_sched_tb_top;
    localparam int PAUSE = 50;
    localparam int REFS  = 8;
    localparam int REFI  = 40;
    localparam int URG   = 8;
    localparam int LOSS  = 12;
    localparam int TCSR  = 1;
    localparam int TCHR  = 2;
    localparam int TRAS  = 4;
    localparam int TRP   = 3;
    localparam int NCAS  = 2;
    localparam int SEQ_LEN = TCSR + TRAS + TRP;   // 8 cycles per refresh
    localparam int INIT_LEN = PAUSE + 1 + (REFS - 1) * (SEQ_LEN + 1) + SEQ_LEN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_urgent, ref_own, host_hold, init_done, dram_ras_n, dram_we_n;
    logic [NCAS-1:0] dram_cas_n;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;

    always #5 clk = ~clk;

    cbr_refresh_sched #(
        .INIT_PAUSE_CYC(PAUSE), .INIT_REFS(REFS), .REFI_CYC(REFI),
        .URGENT_DEBT(URG), .LOSS_DEBT(LOSS),
        .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP), .NUM_CAS(NCAS)
    ) dut_i (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_own(ref_own),
        .host_hold(host_hold), .init_done(init_done),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
    );

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Strobe shape monitor (R4, R5)
    int  cas_lo_run, ras_lo_run, both_hi_run, mon_falls;
    bit  p_ras, p_cas, first_fall, we_bad, pair_bad;

    always @(negedge clk) begin
        if (rst) begin
            cas_lo_run = 0; ras_lo_run = 0; both_hi_run = 0;
            p_ras = 1'b1; p_cas = 1'b1; first_fall = 1'b1;
        end else begin
            if (p_ras && !dram_ras_n)
                check(cas_lo_run == TCSR, "R4", "CAS setup cycles", cas_lo_run, TCSR);
            if (!p_cas && dram_cas_n[0] && !dram_ras_n)
                check(ras_lo_run == TCHR, "R4", "CAS hold cycles", ras_lo_run, TCHR);
            if (!p_ras && dram_ras_n)
                check(ras_lo_run == TRAS, "R4", "RAS low cycles", ras_lo_run, TRAS);
            if (p_cas && !dram_cas_n[0]) begin
                if (!first_fall)
                    check(both_hi_run >= TRP, "R4", "precharge cycles", both_hi_run, TRP);
                first_fall = 1'b0;
                mon_falls++;
            end
            cas_lo_run  = dram_cas_n[0] ? 0 : cas_lo_run + 1;
            ras_lo_run  = dram_ras_n ? 0 : ras_lo_run + 1;
            both_hi_run = (dram_ras_n && dram_cas_n[0]) ? both_hi_run + 1 : 0;
            p_ras = dram_ras_n;
            p_cas = dram_cas_n[0];
        end
        if (dram_we_n !== 1'b1) we_bad = 1'b1;
        if (dram_cas_n[0] !== dram_cas_n[NCAS-1]) pair_bad = 1'b1;
    end

    task automatic do_reset();
        rst = 1'b1;
        ref_gnt = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_to(input int n);
        while (ncyc < n) @(negedge clk);
    endtask

    task automatic wait_init();
        while (!init_done) @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        ref_gnt = 1'b1;
        repeat (2) @(negedge clk);
        check(dram_ras_n && (&dram_cas_n) && dram_we_n, "R1", "strobes high in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 15);
        check(!init_done && !ref_req && !ref_urgent && !ref_own, "R1", "status low in reset",
              {init_done, ref_req, ref_urgent, ref_own}, 0);
        check(host_hold, "R1", "host_hold in reset", host_hold, 1);
        rst = 1'b0;
        @(negedge clk);
        check(!ref_req && !ref_own && dram_ras_n && dram_cas_n[0], "R1", "quiet after release",
              {ref_req, ref_own, dram_ras_n, dram_cas_n[0]}, 3);
    endtask

    // R2, R3: pause then initialisation refreshes
    task automatic t_init();
        int first_cas;
        bit early_req;
        do_reset();
        ref_gnt = 1'b1;
        mon_falls = 0;
        first_cas = -1;
        early_req = 1'b0;
        while (first_cas < 0) begin
            @(negedge clk);
            if (ref_req && ncyc < PAUSE) early_req = 1'b1;
            if (!dram_cas_n[0]) first_cas = ncyc;
        end
        check(!early_req, "R2", "request during pause", early_req, 0);
        check(first_cas == PAUSE + 1, "R2", "first CAS fall cycle", first_cas, PAUSE + 1);
        wait_to(INIT_LEN - 1);
        check(!init_done && host_hold, "R3", "still initialising", init_done, 0);
        @(negedge clk);
        check(init_done == 1'b1, "R3", "init_done cycle", ncyc, INIT_LEN);
        check(mon_falls == REFS, "R3", "init refresh count", mon_falls, REFS);
        check(!host_hold, "R3", "host_hold released", host_hold, 0);
    endtask

    // R6, R7: periodic refresh and handshake
    task automatic t_periodic();
        int e0;
        int first_cas;
        bit stray;
        do_reset();
        ref_gnt = 1'b1;
        wait_init();
        e0 = ncyc;
        stray = 1'b0;
        first_cas = -1;
        while (first_cas < 0) begin
            @(negedge clk);
            if (ncyc < e0 + REFI && (ref_req || ref_own)) stray = 1'b1;
            if (ncyc == e0 + REFI)
                check(ref_req && !ref_own, "R7", "request when owed", {ref_req, ref_own}, 2);
            if (!dram_cas_n[0]) first_cas = ncyc;
        end
        check(!stray, "R7", "grant without request ignored", stray, 0);
        check(first_cas == e0 + REFI + 1, "R6", "first periodic refresh", first_cas - e0, REFI + 1);
        check(ref_own && !ref_req, "R7", "own and request dropped", {ref_own, ref_req}, 2);
        wait_to(e0 + REFI + 1 + SEQ_LEN);
        check(!ref_own && !ref_req, "R7", "own ends after sequence", {ref_own, ref_req}, 0);
        check(!we_bad, "R5", "WE stayed high", we_bad, 0);
        check(!pair_bad, "R4", "CAS bits together", pair_bad, 0);
    endtask

    // R8, R9: debt, urgent, and tick on the completion edge
    task automatic t_debt();
        int e0;
        int f0;
        int n;
        do_reset();
        ref_gnt = 1'b1;
        wait_init();
        e0 = ncyc;
        ref_gnt = 1'b0;
        f0 = mon_falls;
        wait_to(e0 + URG * REFI - 1);
        check(!ref_urgent && !host_hold, "R9", "below urgent", {ref_urgent, host_hold}, 0);
        @(negedge clk);
        check(ref_urgent && host_hold && ref_req, "R9", "urgent at threshold",
              {ref_urgent, host_hold, ref_req}, 7);
        // first refresh starts at e0+352 and completes at e0+360 with a tick
        wait_to(e0 + (URG + 1) * REFI - SEQ_LEN - 1);
        ref_gnt = 1'b1;
        wait_to(e0 + (URG + 1) * REFI);
        check(ref_urgent, "R8", "tick and completion same edge", ref_urgent, 1);
        wait_to(e0 + (URG + 1) * REFI + SEQ_LEN);
        check(ref_urgent, "R8", "debt still at threshold", ref_urgent, 1);
        @(negedge clk);
        check(!ref_urgent, "R8", "debt below threshold", ref_urgent, 0);
        while (ref_req || ref_own) @(negedge clk);
        n = ncyc - e0;
        check(mon_falls - f0 == n / REFI, "R8", "refreshes equal ticks", mon_falls - f0, n / REFI);
    endtask

    // R10: loss of refresh re-runs initialisation
    task automatic t_loss();
        int e0;
        int l0;
        int f0;
        do_reset();
        ref_gnt = 1'b1;
        wait_init();
        e0 = ncyc;
        ref_gnt = 1'b0;
        wait_to(e0 + LOSS * REFI);
        check(init_done, "R10", "still running at loss edge", init_done, 1);
        @(negedge clk);
        l0 = ncyc;
        check(!init_done && !ref_req && host_hold, "R10", "loss drops init",
              {init_done, ref_req, host_hold}, 1);
        ref_gnt = 1'b1;
        f0 = mon_falls;
        wait_to(l0 + PAUSE);
        check(mon_falls == f0 && !ref_own, "R2", "pause repeated", mon_falls - f0, 0);
        @(negedge clk);
        check(!dram_cas_n[0], "R2", "refresh after repeated pause", dram_cas_n[0], 0);
        wait_to(l0 + INIT_LEN - 1);
        check(!init_done, "R10", "re-init not yet done", init_done, 0);
        @(negedge clk);
        check(init_done, "R10", "re-init done", init_done, 1);
        check(mon_falls - f0 == REFS, "R10", "re-init refresh count", mon_falls - f0, REFS);
    endtask

    initial begin
        we_bad = 1'b0;
        pair_bad = 1'b0;
        mon_falls = 0;
        @(negedge clk);
        t_reset();
        t_init();
        t_periodic();
        t_debt();
        t_loss();
        check(!we_bad, "R5", "WE high over run", we_bad, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule